// File: doc/BRIEF.md
# Character Row Line Buffer and Attribute Pipeline

This block is the character-row datapath of a text/bitmap video controller. It runs on the dot clock. On the first raster line of a character row (a fetch line), it takes one 12-bit entry per character column from the matrix data input and stores it in a small line buffer. Each entry is an 8-bit code and a 4-bit colour nibble. On the other raster lines of the same row, it reads the same entries back out of the buffer.

For each column, the block issues a pattern-fetch request with its address. It holds the entry's attribute for one character slot, until the pattern byte comes back. It then places the attribute in a pair of per-character colour registers and serialises the pattern byte, most significant bit first.

In bitmap mode the code byte carries two colours directly, so no second memory read is needed. A 3-bit fine-scroll value moves the whole line start to the right by 0 to 7 dots. Outside the active window the output is the background colour.

Top module: `charrow_pipe`

## Requirements
- R1: Each entry is 12 bits: bits 11:4 are the code and bits 3:0 are the attribute. On a fetch line, the entry for column k is taken from `mat_data` in that column's access cycle and stored in buffer row k. On any other line, `mat_data` is ignored and the entry stored for column k on the most recent fetch line is used.
- R2: The buffer row is chosen by a circulating one-hot pointer, not by a counter and decoder. The pointer returns to row 0 at each `line_start` and advances one row per access, so access k uses row k.
- R3: At most one buffer row is written in any cycle.
- R4: Count cycles from the `line_start` edge, where the cycle right after that edge is cycle 1, and let F be `fine_scroll`. The access for column k (0 ≤ k < COLS) then falls in cycle F+1+8k. `pat_req` is high in exactly those cycles.
- R5: In text mode, `pat_addr` is {code, `char_line`}. It is valid in the access cycle itself, with no register between `mat_data` and `pat_addr` on a fetch line.
- R6: In bitmap mode, `pat_addr` is {column index as 8 bits, `char_line`}. A set pattern bit shows code bits 7:4 and a clear bit shows code bits 3:0.
- R7: `pat_data` for column k is sampled in cycle F+9+8k. The attribute of column k is held for one slot, until that cycle, and then colours the pixels of column k only.
- R8: In text mode, a set pattern bit shows the attribute and a clear bit shows `bg_color`.
- R9: Line pixel p (0 ≤ p < 8·COLS) appears on `pix_out` in cycle F+10+p. Bit 7−(p mod 8) of column p/8's pattern is shown, so bits go out MSB first.
- R10: Before the first pixel and after the last one, `pix_out` equals `bg_color`.
- R11: During and after reset, before any `line_start`, `pat_req` is 0 and `pix_out` equals `bg_color`.
- R12: `fetch_line`, `bitmap_mode`, `fine_scroll` and `char_line` are sampled only at `line_start`. Changing them in mid-line has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that begins a raster line |
| fetch_line | input | 1 | Line is the fetch line of its character row |
| bitmap_mode | input | 1 | 1 = bitmap mode, 0 = text mode |
| fine_scroll | input | 3 | Dot offset of the line start |
| char_line | input | 3 | Raster line within the character row |
| bg_color | input | 4 | Global background colour |
| mat_data | input | 12 | Matrix entry {code, attribute} |
| pat_req | output | 1 | Pattern fetch request (access cycle) |
| pat_addr | output | 11 | Pattern fetch address |
| pat_data | input | 8 | Returned pattern byte |
| pix_out | output | 4 | Pixel colour |

## Verification
The hardest cases to reach are two. The first is a read-back line whose `mat_data` carries unrelated values while the buffer has to supply the stored entries. The second is a pattern byte for column k that is still being sampled in the same cycle the request for column k+1 goes out. The bench drives random values on `mat_data` outside access cycles and on every non-fetch line. It answers each request only after the following clock edge, so a design that samples early or late sees the wrong byte. One line also changes every mode input in mid-line, and lines alternate between fetch and read-back with different scroll and mode settings.

// File: rtl/charrow_pkg.sv
// Shared widths and entry layout for the character row pipeline.
// Assumes a 12-bit entry: code in the upper byte, attribute below it.
package charrow_pkg;
    timeunit 1ns; timeprecision 100ps;
    localparam int CODE_W  = 8;
    localparam int ATTR_W  = 4;
    localparam int ENTRY_W = CODE_W + ATTR_W;
    localparam int SUBL_W  = 3;
    localparam int PIX_W   = 8;
    localparam int ADDR_W  = CODE_W + SUBL_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [ATTR_W-1:0] attr;
    } cr_entry_t;
endpackage

// File: rtl/charrow_ring.sv
// One-hot row pointer that circulates over N rows.
// Assumes 'home' takes priority over 'step'; resets to row 0.
module charrow_ring #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         home,
    input  logic         step,
    output logic [N-1:0] sel
);
    timeunit 1ns; timeprecision 100ps;

    // Rotate the single set bit one row per access.
    always_ff @(posedge clk) begin
        if (!rst_n || home) sel <= {{(N-1){1'b0}}, 1'b1};
        else if (step)      sel <= {sel[N-2:0], sel[N-1]};
    end

    a_r2_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);
    a_r2_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
        home |=> sel[0]);
endmodule

// File: rtl/charrow_linebuf.sv
// Line buffer of N entries addressed by a one-hot select.
// Assumes at most one select bit is set; the read is an AND-OR mux.
module charrow_linebuf #(
    parameter int N = 40,
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sel,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    timeunit 1ns; timeprecision 100ps;

    logic [W-1:0] mem [N];
    logic [N-1:0] wen;

    // Per-row write enable from the pointer.
    always_comb wen = sel & {N{wr}};

    // Store into the one selected row.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++)
            if (wen[i]) mem[i] <= wdata;
    end

    // Combine the selected row onto the read port.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (sel[i]) rdata = rdata | mem[i];
    end

    a_r3_single_row_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen));
endmodule

// File: rtl/charrow_seq.sv
// Slot sequencer: waits the fine-scroll lead, then runs 8-dot slots.
// Slot k < COLS issues an access, and slot k in 1..COLS loads a pattern.
// Display runs from the first load until the slot after the last load.
module charrow_seq #(
    parameter int COLS = 40,
    localparam int CW = $clog2(COLS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [2:0]    fine_scroll,
    output logic          access,
    output logic          load,
    output logic          disp,
    output logic [CW-1:0] col
);
    timeunit 1ns; timeprecision 100ps;

    localparam logic [CW-1:0] NCOL = CW'(COLS);
    localparam logic [CW-1:0] LAST = CW'(COLS + 1);

    logic       run;
    logic [2:0] lead;
    logic [2:0] ph;
    logic       tick, finish;

    // Decode the slot events from the phase and column.
    always_comb begin
        tick   = run && (lead == 3'd0);
        access = tick && (ph == 3'd0) && (col < NCOL);
        load   = tick && (ph == 3'd0) && (col != '0) && (col <= NCOL);
        finish = tick && (ph == 3'd0) && (col == LAST);
    end

    // Lead countdown, dot phase and column counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; lead <= '0; ph <= '0; col <= '0;
        end else if (line_start) begin
            run <= 1'b1; lead <= fine_scroll; ph <= '0; col <= '0;
        end else if (run) begin
            if (lead != 3'd0)  lead <= lead - 3'd1;
            else if (finish)   run  <= 1'b0;
            else begin
                ph <= ph + 3'd1;
                if (ph == 3'd7) col <= col + 1'b1;
            end
        end
    end

    // Display window flag: opened by the first load, closed by finish.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start || finish) disp <= 1'b0;
        else if (load)                      disp <= 1'b1;
    end

    a_r4_access_gap: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !access);
    a_r9_disp_opens_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp) |-> $past(load));
endmodule

// File: rtl/charrow_pixel.sv
// Attribute hold stage, per-character colour pair and pixel shifter.
// Assumes 'load' comes one slot after the 'capture' of the same column.
module charrow_pixel
    import charrow_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               load,
    input  logic               disp,
    input  logic               bitmap,
    input  cr_entry_t          entry_in,
    input  logic [ATTR_W-1:0]  bg_color,
    input  logic [PIX_W-1:0]   pat_data,
    output logic [ATTR_W-1:0]  pix_out
);
    timeunit 1ns; timeprecision 100ps;

    cr_entry_t         hold_q;
    logic [ATTR_W-1:0] c_one, c_zero;
    logic [PIX_W-1:0]  shreg;

    // One-slot hold for the entry while its pattern is fetched.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= entry_in;
    end

    // Colour pair, filled the same way the global colours are used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_one <= '0; c_zero <= '0;
        end else if (load) begin
            if (bitmap) begin
                c_one  <= hold_q.code[CODE_W-1 -: ATTR_W];
                c_zero <= hold_q.code[ATTR_W-1:0];
            end else begin
                c_one  <= hold_q.attr;
                c_zero <= bg_color;
            end
        end
    end

    // Pattern shifter, MSB first, one bit per dot.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (load) shreg <= pat_data;
        else if (disp) shreg <= {shreg[PIX_W-2:0], 1'b0};
    end

    // Pixel colour select.
    always_comb pix_out = disp ? (shreg[PIX_W-1] ? c_one : c_zero) : bg_color;

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(hold_q));
endmodule

// File: rtl/charrow_pipe.sv
// Top of the character row path: latches the line modes, keeps the
// line buffer, drives the pattern fetch address and the pixel output.
// Assumes CODE_W is wide enough to hold a column index.
module charrow_pipe
    import charrow_pkg::*;
#(
    parameter int COLS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              fetch_line,
    input  logic              bitmap_mode,
    input  logic [2:0]        fine_scroll,
    input  logic [2:0]        char_line,
    input  logic [3:0]        bg_color,
    input  logic [11:0]       mat_data,
    output logic              pat_req,
    output logic [10:0]       pat_addr,
    input  logic [7:0]        pat_data,
    output logic [3:0]        pix_out
);
    timeunit 1ns; timeprecision 100ps;

    localparam int CW = $clog2(COLS + 2);

    logic              fetch_q, bitmap_q;
    logic [SUBL_W-1:0] cline_q;
    logic              access, load, disp;
    logic [CW-1:0]     col;
    logic [COLS-1:0]   sel;
    logic [ENTRY_W-1:0] rdata;
    cr_entry_t         entry_now;

    // Sample the per-line mode inputs at the line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= 1'b0; bitmap_q <= 1'b0; cline_q <= '0;
        end else if (line_start) begin
            fetch_q <= fetch_line; bitmap_q <= bitmap_mode; cline_q <= char_line;
        end
    end

    charrow_seq #(.COLS(COLS)) u_seq (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .fine_scroll(fine_scroll), .access(access), .load(load),
        .disp(disp), .col(col)
    );

    charrow_ring #(.N(COLS)) u_ring (
        .clk(clk), .rst_n(rst_n), .home(line_start), .step(access), .sel(sel)
    );

    charrow_linebuf #(.N(COLS), .W(ENTRY_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(access && fetch_q),
        .wdata(mat_data), .rdata(rdata)
    );

    // Current entry: live matrix data on fetch lines, buffer otherwise.
    always_comb entry_now = fetch_q ? cr_entry_t'(mat_data) : cr_entry_t'(rdata);

    // Pattern request and address, unregistered.
    always_comb begin
        pat_req = access;
        if (bitmap_q) pat_addr = {{(CODE_W-CW){1'b0}}, col, cline_q};
        else          pat_addr = {entry_now.code, cline_q};
    end

    charrow_pixel u_pix (
        .clk(clk), .rst_n(rst_n), .capture(access), .load(load),
        .disp(disp), .bitmap(bitmap_q), .entry_in(entry_now),
        .bg_color(bg_color), .pat_data(pat_data), .pix_out(pix_out)
    );

    a_r12_modes_held: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ($stable(fetch_q) && $stable(bitmap_q) && $stable(cline_q)));
endmodule

// File: tb/charrow_pipe_tb.sv
module charrow_pipe_tb;
    timeunit 1ns; timeprecision 100ps;

    localparam int COLS = 40;

    logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0;
    logic fetch_line = 1'b0, bitmap_mode = 1'b0;
    logic [2:0] fine_scroll = '0, char_line = '0;
    logic [3:0] bg_color = 4'h0;
    logic [11:0] mat_data = '0;
    logic pat_req;
    logic [10:0] pat_addr;
    logic [7:0] pat_data = '0;
    logic [3:0] pix_out;

    int vectors = 0, fails = 0;
    bit done = 1'b0;
    logic [11:0] stored [COLS];
    logic [11:0] ent [COLS];

    always #2.5 clk = ~clk;

    charrow_pipe #(.COLS(COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .fetch_line(fetch_line),
        .bitmap_mode(bitmap_mode), .fine_scroll(fine_scroll), .char_line(char_line),
        .bg_color(bg_color), .mat_data(mat_data), .pat_req(pat_req),
        .pat_addr(pat_addr), .pat_data(pat_data), .pix_out(pix_out)
    );

    function automatic logic [7:0] patfn(logic [10:0] a);
        return 8'((a * 29) ^ (a >> 3) ^ 11'h5a);
    endfunction

    function automatic logic [11:0] matfn(int id, int k);
        return 12'((id * 97 + k * 13 + 5) ^ (k << 7));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Run one raster line against the behavioural reference.
    task automatic run_line(int id, bit fetch, bit bmp, int f, int cl, logic [3:0] bg, bit poke);
        logic [10:0] next_addr = '0;
        bit have = 1'b0;
        int last = f + 10 + 8 * COLS + 4;
        for (int k = 0; k < COLS; k++) begin
            if (fetch) begin ent[k] = matfn(id, k); stored[k] = ent[k]; end
            else ent[k] = stored[k];
        end
        @(negedge clk);
        line_start = 1'b1; fetch_line = fetch; bitmap_mode = bmp;
        fine_scroll = 3'(f); char_line = 3'(cl); bg_color = bg;
        @(posedge clk); #1 line_start = 1'b0;
        for (int c = 1; c <= last; c++) begin
            int a = c - f - 1;
            int p = c - f - 10;
            bit req_e = (a >= 0) && (a % 8 == 0) && (a / 8 < COLS);
            logic [3:0] pix_e;
            @(negedge clk);
            // R1: mat_data carries the entry only in fetch-line access cycles
            mat_data = (fetch && req_e) ? matfn(id, a / 8) : 12'($urandom);
            if (poke && c == 60) begin  // R12: mid-line mode changes
                bitmap_mode = ~bmp; fetch_line = ~fetch;
                fine_scroll = 3'(f + 3); char_line = 3'(cl + 1);
            end
            #1;
            chk(pat_req == req_e, "R4 pat_req timing", pat_req, req_e);
            if (req_e) begin
                logic [10:0] ae;
                int k = a / 8;
                ae = bmp ? {8'(k), 3'(cl)} : {ent[k][11:4], 3'(cl)};
                chk(pat_addr == ae, bmp ? "R6 bitmap pat_addr R2" : "R5 text pat_addr R1 R2",
                    pat_addr, ae);
                next_addr = pat_addr; have = 1'b1;
            end
            if (p >= 0 && p < 8 * COLS) begin
                logic [11:0] e = ent[p / 8];
                logic [7:0] pt = patfn(bmp ? {8'(p / 8), 3'(cl)} : {e[11:4], 3'(cl)});
                bit b = pt[7 - (p % 8)];
                pix_e = bmp ? (b ? e[11:8] : e[7:4]) : (b ? e[3:0] : bg);
                chk(pix_out == pix_e,
                    bmp ? "R6 R7 R9 R1 R12 bitmap pixel" : "R8 R7 R9 R1 R12 text pixel",
                    pix_out, pix_e);
            end else begin
                chk(pix_out == bg, "R10 background outside window", pix_out, bg);
            end
            @(posedge clk); #1;
            // R7: the byte for column k is answered after the edge ending its access
            if (have) begin pat_data = patfn(next_addr); have = 1'b0; end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pat_req == 1'b0, "R11 reset pat_req", pat_req, 0);
        chk(pix_out == bg_color, "R11 reset pix_out", pix_out, bg_color);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(pat_req == 1'b0, "R11 idle pat_req", pat_req, 0);
            chk(pix_out == bg_color, "R11 idle pix_out", pix_out, bg_color);
        end
        run_line(1, 1'b1, 1'b0, 0, 0, 4'h6, 1'b0);  // fetch, text
        run_line(2, 1'b0, 1'b0, 3, 5, 4'h2, 1'b1);  // read-back, mid-line pokes
        run_line(3, 1'b0, 1'b0, 7, 7, 4'hb, 1'b0);  // read-back, max scroll
        run_line(4, 1'b1, 1'b1, 5, 2, 4'h0, 1'b0);  // fetch, bitmap
        run_line(5, 1'b0, 1'b1, 0, 3, 4'h9, 1'b1);  // read-back bitmap
        run_line(6, 1'b1, 1'b0, 2, 0, 4'hf, 1'b0);  // overwrite buffer
        run_line(7, 1'b0, 1'b0, 1, 6, 4'h3, 1'b0);  // read new entries
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule